// File: doc/BRIEF.md
# Low-Power Mode Transition Sequencer

This block controls when a voltage regulator moves between its normal operating point, a deep-sleep point (the normal code with an offset added) and a suspend point. It watches an active-low deep-sleep request, an active-high suspend request and a completion flag from the DAC slew stepper. From these it drives four things: a target-voltage select, a flag that forces PWM or allows pulse skipping, an active-low driver-disable line for slave phases, and two blanking strobes. One strobe holds power-good high. The other holds clock-enable low.

Leaving a low-power mode takes effect at once. Entering one happens in stages. The sequencer first waits for the slew stepper to report that it has reached its final code. It then counts a fixed delay before it drops driver-disable. After a second fixed delay it allows pulse skipping. Any change on either request line starts status blanking. The blanking ends only after the slew has finished and a further counted delay has passed. A request change that arrives during an entry sequence cancels that sequence and starts it again from the new change.

All delays are counted in cycles of the block clock. The DAC stepping and all analog regulation are handled elsewhere.

Top module: `lpm_sequencer`

## Requirements
- R1: While the synchronous reset is high, every output takes its rest value at the next clock edge: `vsel`=2'b00, `pwm_force`=1, `drv_dis_n`=1, `pg_blank`=0, `clken_blank`=0. This holds whatever the request inputs are.
- R2: `vsel` is registered and follows the inputs one cycle after they are sampled. The value is 2'b00 when `sleep_n`=1 and `susp_req`=0. It is 2'b01 (normal code plus offset) when `sleep_n`=0 and `susp_req`=0. It is 2'b10 when `susp_req`=1.
- R3: When `susp_req`=1 and `sleep_n`=0 at the same time, `vsel` is 2'b10. Changing `sleep_n` while suspend is held does not change `vsel`.
- R4: In the cycle after the block samples a change on either request line, `pwm_force`=1 and `drv_dis_n`=1.
- R5: During an entry into a low-power mode, `drv_dis_n` falls at the DRV_DLY-th clock edge (default 32). Edges are counted from the edge at which `slew_done` is first sampled high after the request change. The edge that samples the change does not count as that first edge.
- R6: `pwm_force` falls SKIP_DLY clock edges (default 30) after `drv_dis_n` falls. `pwm_force` is never 0 while `drv_dis_n` is 1.
- R7: A change to the normal request (`sleep_n`=1, `susp_req`=0) takes effect on the next edge: `vsel`=2'b00, `pwm_force`=1 and `drv_dis_n`=1. No counted delay applies. Pulse skipping and driver-disable happen only while a low-power target is selected.
- R8: After any change on either request line, `pg_blank` and `clken_blank` go to 1 on the next edge. Both stay at 1 until BLANK_DLY edges (default 32) after `slew_done` is first sampled high following that change.
- R9: A request change that arrives during an entry sequence restarts the sequence. The delays of R5 and R6 are measured from the `slew_done` that follows the new change.
- R10: If `slew_done` never rises after a change, the block stays at `drv_dis_n`=1, `pwm_force`=1 and `pg_blank`=1. If `slew_done` is high while the normal point is selected, `drv_dis_n` and `pwm_force` stay at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timing clock; every delay is counted in its cycles |
| rst | input | 1 | Synchronous reset, active high |
| sleep_n | input | 1 | Deep-sleep request, active low |
| susp_req | input | 1 | Suspend request, active high |
| slew_done | input | 1 | High once the DAC slew stepper holds its final code |
| vsel | output | 2 | Target select: 00 normal, 01 normal plus offset, 10 suspend |
| pwm_force | output | 1 | 1 = forced PWM, 0 = pulse skipping allowed |
| drv_dis_n | output | 1 | Active-low driver-disable for slave phases |
| pg_blank | output | 1 | 1 = hold power-good high |
| clken_blank | output | 1 | 1 = hold clock-enable low |

## Verification
The bench applies the following request patterns. Each one answers a separate question.

- **Plain deep-sleep entry and exit.** Entry shows whether both entry delays are counted from the first sampled `slew_done` rather than from the request edge. The one-cycle checks on either side of each expected edge catch any off-by-one. Exit shows that leaving has no delay.
- **Suspend plus deep-sleep held together.** This separates the suspend-priority rule from the plain deep-sleep mapping.
- **Request flip during an entry.** This shows whether the counters restart or keep running.
- **`slew_done` withheld, and `slew_done` raised while in normal mode.** These show that the flag alone never starts an entry.
- **Reset during low power.** This confirms that reset overrides a completed sequence.

// File: rtl/lpm_pkg.sv
`timescale 1ns/1ps
package lpm_pkg;

    typedef enum logic [1:0] {
        VSEL_NORM = 2'b00,
        VSEL_OFFS = 2'b01,
        VSEL_SUSP = 2'b10
    } vsel_e;

    typedef enum logic [2:0] {
        SEQ_RUN,
        SEQ_WAIT,
        SEQ_DRV,
        SEQ_SKIP,
        SEQ_LOW
    } seq_e;

    typedef enum logic [1:0] {
        BL_OFF,
        BL_WAIT,
        BL_CNT
    } blank_e;

    typedef struct packed {
        logic  chg;
        logic  lp;
        vsel_e tgt;
    } req_t;

    function automatic vsel_e pick_target(input logic sleep_n, input logic susp);
        if (susp)
            return VSEL_SUSP;
        else if (!sleep_n)
            return VSEL_OFFS;
        else
            return VSEL_NORM;
    endfunction

    function automatic logic wants_lowpower(input logic sleep_n, input logic susp);
        return susp | ~sleep_n;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/lpm_req_detect.sv
`timescale 1ns/1ps
module lpm_req_detect
    import lpm_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  sleep_n,
    input  logic  susp_req,
    output req_t  req,
    output vsel_e vsel_q
);

    logic sleep_n_q;
    logic susp_q;

    always_comb begin
        req.chg = (sleep_n != sleep_n_q) | (susp_req != susp_q);
        req.lp  = wants_lowpower(sleep_n, susp_req);
        req.tgt = pick_target(sleep_n, susp_req);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sleep_n_q <= 1'b1;
            susp_q    <= 1'b0;
            vsel_q    <= VSEL_NORM;
        end else begin
            sleep_n_q <= sleep_n;
            susp_q    <= susp_req;
            vsel_q    <= req.tgt;
        end
    end

    // R3
    susp_priority_chk: assert property (@(posedge clk) disable iff (rst)
        susp_req |=> (vsel_q == VSEL_SUSP));

endmodule

// File: rtl/lpm_entry_seq.sv
`timescale 1ns/1ps
module lpm_entry_seq
    import lpm_pkg::*;
#(
    parameter int DRV_DLY  = 32,
    parameter int SKIP_DLY = 30
) (
    input  logic clk,
    input  logic rst,
    input  logic chg,
    input  logic lp,
    input  logic slew_done,
    output logic pwm_force,
    output logic drv_dis_n
);

    localparam int MAXD = max2(DRV_DLY, SKIP_DLY);
    localparam int CW   = $clog2(MAXD + 1);
    localparam logic [CW-1:0] DRV_LAST  = CW'(DRV_DLY - 1);
    localparam logic [CW-1:0] SKIP_LAST = CW'(SKIP_DLY - 1);

    seq_e          state;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= SEQ_RUN;
            cnt       <= '0;
            pwm_force <= 1'b1;
            drv_dis_n <= 1'b1;
        end else if (chg) begin
            state     <= lp ? SEQ_WAIT : SEQ_RUN;
            cnt       <= '0;
            pwm_force <= 1'b1;
            drv_dis_n <= 1'b1;
        end else begin
            unique case (state)
                SEQ_RUN: begin
                    cnt <= '0;
                end
                SEQ_WAIT: begin
                    if (slew_done) begin
                        state <= SEQ_DRV;
                        cnt   <= '0;
                    end
                end
                SEQ_DRV: begin
                    if (cnt == DRV_LAST) begin
                        state     <= SEQ_SKIP;
                        cnt       <= '0;
                        drv_dis_n <= 1'b0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                SEQ_SKIP: begin
                    if (cnt == SKIP_LAST) begin
                        state     <= SEQ_LOW;
                        cnt       <= '0;
                        pwm_force <= 1'b0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                SEQ_LOW: begin
                    cnt <= '0;
                end
                default: begin
                    state <= SEQ_RUN;
                    cnt   <= '0;
                end
            endcase
        end
    end

    // R4
    chg_forces_pwm_chk: assert property (@(posedge clk) disable iff (rst)
        chg |=> (pwm_force && drv_dis_n));

    // R6
    skip_after_drv_chk: assert property (@(posedge clk) disable iff (rst)
        !pwm_force |-> !drv_dis_n);

    // R5
    drv_fall_from_count_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(drv_dis_n) |-> ($past(state) == SEQ_DRV));

endmodule

// File: rtl/lpm_blank_timer.sv
`timescale 1ns/1ps
module lpm_blank_timer
    import lpm_pkg::*;
#(
    parameter int BLANK_DLY = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic chg,
    input  logic slew_done,
    output logic blank
);

    localparam int CW = $clog2(BLANK_DLY + 1);
    localparam logic [CW-1:0] BL_LAST = CW'(BLANK_DLY - 1);

    blank_e        state;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= BL_OFF;
            cnt   <= '0;
            blank <= 1'b0;
        end else if (chg) begin
            state <= BL_WAIT;
            cnt   <= '0;
            blank <= 1'b1;
        end else begin
            unique case (state)
                BL_OFF: cnt <= '0;
                BL_WAIT: begin
                    if (slew_done) begin
                        state <= BL_CNT;
                        cnt   <= '0;
                    end
                end
                BL_CNT: begin
                    if (cnt == BL_LAST) begin
                        state <= BL_OFF;
                        cnt   <= '0;
                        blank <= 1'b0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: begin
                    state <= BL_OFF;
                    cnt   <= '0;
                end
            endcase
        end
    end

    // R8
    blank_on_chg_chk: assert property (@(posedge clk) disable iff (rst)
        chg |=> blank);

    // R8
    blank_end_counted_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(blank) |-> ($past(state) == BL_CNT));

endmodule

// File: rtl/lpm_sequencer.sv
`timescale 1ns/1ps
module lpm_sequencer
    import lpm_pkg::*;
#(
    parameter int DRV_DLY   = 32,
    parameter int SKIP_DLY  = 30,
    parameter int BLANK_DLY = 32
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sleep_n,
    input  logic       susp_req,
    input  logic       slew_done,
    output logic [1:0] vsel,
    output logic       pwm_force,
    output logic       drv_dis_n,
    output logic       pg_blank,
    output logic       clken_blank
);

    req_t  req;
    vsel_e vsel_q;
    logic  blank;

    lpm_req_detect u_req (
        .clk      (clk),
        .rst      (rst),
        .sleep_n  (sleep_n),
        .susp_req (susp_req),
        .req      (req),
        .vsel_q   (vsel_q)
    );

    lpm_entry_seq #(
        .DRV_DLY  (DRV_DLY),
        .SKIP_DLY (SKIP_DLY)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .chg       (req.chg),
        .lp        (req.lp),
        .slew_done (slew_done),
        .pwm_force (pwm_force),
        .drv_dis_n (drv_dis_n)
    );

    lpm_blank_timer #(
        .BLANK_DLY (BLANK_DLY)
    ) u_blank (
        .clk       (clk),
        .rst       (rst),
        .chg       (req.chg),
        .slew_done (slew_done),
        .blank     (blank)
    );

    assign vsel        = vsel_q;
    assign pg_blank    = blank;
    assign clken_blank = blank;

    // R7
    drv_only_lowpwr_chk: assert property (@(posedge clk) disable iff (rst)
        !drv_dis_n |-> (vsel_q != VSEL_NORM));

    // R7
    skip_only_lowpwr_chk: assert property (@(posedge clk) disable iff (rst)
        !pwm_force |-> (vsel_q != VSEL_NORM));

    // R7
    exit_immediate_chk: assert property (@(posedge clk) disable iff (rst)
        (req.chg && !req.lp) |=> (drv_dis_n && pwm_force && vsel_q == VSEL_NORM));

endmodule

// File: tb/lpm_sequencer_tb.sv
`timescale 1ns/1ps
module lpm_sequencer_tb;

    localparam int DRV  = 32;
    localparam int SKIP = 30;
    localparam int BLNK = 32;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sleep_n = 1'b1;
    logic       susp_req = 1'b0;
    logic       slew_done = 1'b0;
    logic [1:0] vsel;
    logic       pwm_force, drv_dis_n, pg_blank, clken_blank;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    lpm_sequencer #(.DRV_DLY(DRV), .SKIP_DLY(SKIP), .BLANK_DLY(BLNK)) u_dut (
        .clk(clk), .rst(rst), .sleep_n(sleep_n), .susp_req(susp_req),
        .slew_done(slew_done), .vsel(vsel), .pwm_force(pwm_force),
        .drv_dis_n(drv_dis_n), .pg_blank(pg_blank), .clken_blank(clken_blank)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    // slew finishes after 'lag' cycles; returns with edge E0 (first sample) just passed
    task automatic finish_slew(input int lag);
        tick(lag);
        slew_done = 1'b1;
        tick(1);
    endtask

    task automatic t_reset();
        rst = 1'b1; sleep_n = 1'b1; susp_req = 1'b0; slew_done = 1'b0;
        tick(2);
        chk("R1", "vsel", vsel, 0);
        chk("R1", "pwm_force", pwm_force, 1);
        chk("R1", "drv_dis_n", drv_dis_n, 1);
        chk("R1", "pg_blank", pg_blank, 0);
        chk("R1", "clken_blank", clken_blank, 0);
        rst = 1'b0;
        tick(2);
    endtask

    task automatic t_normal_slew();
        slew_done = 1'b1;
        tick(40);
        chk("R10", "drv_dis_n slew in normal", drv_dis_n, 1);
        chk("R10", "pwm_force slew in normal", pwm_force, 1);
        chk("R10", "pg_blank slew in normal", pg_blank, 0);
        slew_done = 1'b0;
        tick(1);
    endtask

    task automatic t_sleep_entry();
        sleep_n = 1'b0; slew_done = 1'b0;
        tick(1);
        chk("R2", "vsel offset", vsel, 1);
        chk("R4", "pwm_force on change", pwm_force, 1);
        chk("R4", "drv_dis_n on change", drv_dis_n, 1);
        chk("R8", "pg_blank on change", pg_blank, 1);
        chk("R8", "clken_blank on change", clken_blank, 1);
        finish_slew(4);
        tick(DRV - 1);
        chk("R5", "drv_dis_n one before", drv_dis_n, 1);
        chk("R8", "pg_blank one before", pg_blank, 1);
        tick(1);
        chk("R5", "drv_dis_n at delay", drv_dis_n, 0);
        chk("R8", "pg_blank released", pg_blank, 0);
        chk("R8", "clken_blank released", clken_blank, 0);
        chk("R6", "pwm_force at drv fall", pwm_force, 1);
        tick(SKIP - 1);
        chk("R6", "pwm_force one before", pwm_force, 1);
        tick(1);
        chk("R6", "pwm_force at delay", pwm_force, 0);
    endtask

    task automatic t_sleep_exit();
        sleep_n = 1'b1; slew_done = 1'b0;
        tick(1);
        chk("R7", "vsel normal", vsel, 0);
        chk("R7", "pwm_force on exit", pwm_force, 1);
        chk("R7", "drv_dis_n on exit", drv_dis_n, 1);
        chk("R8", "pg_blank on exit", pg_blank, 1);
        finish_slew(2);
        tick(BLNK - 1);
        chk("R8", "pg_blank exit one before", pg_blank, 1);
        tick(1);
        chk("R8", "pg_blank exit released", pg_blank, 0);
        chk("R7", "drv_dis_n stays high", drv_dis_n, 1);
    endtask

    task automatic t_restart();
        susp_req = 1'b1; sleep_n = 1'b0; slew_done = 1'b0;
        tick(1);
        chk("R3", "vsel both requests", vsel, 2);
        finish_slew(2);
        tick(10);
        sleep_n = 1'b1; slew_done = 1'b0;
        tick(1);
        chk("R3", "vsel sleep_n flip in suspend", vsel, 2);
        chk("R9", "drv_dis_n after restart", drv_dis_n, 1);
        chk("R9", "pwm_force after restart", pwm_force, 1);
        finish_slew(3);
        tick(DRV - 1);
        chk("R9", "drv_dis_n one before", drv_dis_n, 1);
        tick(1);
        chk("R9", "drv_dis_n restarted delay", drv_dis_n, 0);
        tick(SKIP);
        chk("R9", "pwm_force restarted delay", pwm_force, 0);
        sleep_n = 1'b0;
        tick(1);
        chk("R3", "vsel sleep_n low in suspend", vsel, 2);
        susp_req = 1'b0; sleep_n = 1'b1; slew_done = 1'b0;
        tick(1);
        chk("R7", "vsel after suspend exit", vsel, 0);
        chk("R7", "drv_dis_n after suspend exit", drv_dis_n, 1);
        finish_slew(1);
        tick(BLNK);
        slew_done = 1'b0;
    endtask

    task automatic t_no_slew();
        susp_req = 1'b1; slew_done = 1'b0;
        tick(1);
        chk("R2", "vsel suspend", vsel, 2);
        tick(80);
        chk("R10", "drv_dis_n without slew", drv_dis_n, 1);
        chk("R10", "pwm_force without slew", pwm_force, 1);
        chk("R10", "pg_blank without slew", pg_blank, 1);
    endtask

    task automatic t_reset_in_lp();
        finish_slew(1);
        tick(DRV + SKIP);
        chk("R6", "pwm_force suspend settled", pwm_force, 0);
        rst = 1'b1;
        tick(1);
        chk("R1", "vsel reset in lp", vsel, 0);
        chk("R1", "pwm_force reset in lp", pwm_force, 1);
        chk("R1", "drv_dis_n reset in lp", drv_dis_n, 1);
        chk("R1", "pg_blank reset in lp", pg_blank, 0);
        rst = 1'b0;
        tick(1);
    endtask

    initial begin
        #(5.0 * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        t_reset();
        t_normal_slew();
        t_sleep_entry();
        t_sleep_exit();
        t_restart();
        t_no_slew();
        t_reset_in_lp();
        summary();
    end

endmodule